// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register File

This block holds the bus-master control registers of a two-channel disk controller. A host reaches them through a 16-byte I/O window. Address bit 3 picks the channel, and the low three bits pick a register within that channel. Each channel has three registers: a command byte, a status byte, and a 32-bit pointer to a table of eight-byte region descriptors. Software may write the pointer one byte at a time or in wider pieces.

Setting the start bit makes the channel walk its descriptor table. The channel asks for each descriptor over a shared memory-read port, which the two channels take turns on. It then presents the region (base address, byte count, direction) to a data mover through a valid/ready handshake. When the mover accepts the region flagged as the last one, the channel stops and updates its status byte: active is cleared, error is cleared and interrupt is set. Writing the command byte with start clear rewinds the table index and cancels any walk that is running.

Top module: `bmdma_regfile`

## Requirements
- R1: `acc_addr[3]` selects the channel and `acc_addr[2:0]` selects the register: 0 is command, 2 is status, and 4 to 7 are pointer bytes 0 to 3. Pointer byte k is bits 8k+7:8k. An access to one channel never changes the other channel.
- R2: Offsets 1 and 3 read as zero, ignore writes and never raise `acc_err`.
- R3: A pointer access moves `acc_size`+1 bytes, starting at pointer byte `acc_addr[1:0]`, carried in the low byte lanes of the data bus. If the starting byte plus the length runs past byte 3, the access is rejected with `acc_err` and nothing changes.
- R4: A status access with `acc_size` other than 0 (one byte) is rejected with `acc_err`, changes nothing and reads zero.
- R5: Status bit 0 is active, bit 1 is error and bit 2 is interrupt. An accepted status write stores the whole byte.
- R6: A command write with bit 0 (start) clear stores the byte unchanged, sets the table index to zero, and cancels any fetch or region offer that is running.
- R7: A command write with start set stores the byte ANDed with 0x09 and sets status active. An idle channel then fetches the descriptor at pointer + 8 × index, using the index left over from earlier.
- R8: A descriptor is 64 bits wide: base in bits 31:0, byte count in bits 47:32, and the last-entry flag in bit 63. It is presented on the region port together with `rgn_to_mem` = command bit 3.
- R9: When the mover accepts a region that is not the last, the channel adds one to its index and fetches the next entry, 8 bytes further on.
- R10: When the mover accepts the last region, the channel clears active and error, sets interrupt, keeps the other status bits, and goes idle.
- R11: The memory port is shared. A request that is waiting keeps its channel and address until it is granted. When both channels start asking in the same cycle, channel 0 is served first.
- R12: `acc_rdata` and `acc_err` are valid in the cycle after `acc_valid`. Writes and rejected accesses return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Window offset: bit 3 is the channel, bits 2:0 the register |
| acc_size | input | 2 | Number of bytes minus one |
| acc_wdata | input | 32 | Write data, low lanes first |
| acc_rdata | output | 32 | Read data, one cycle after the access |
| acc_err | output | 1 | Access rejected, one cycle after the access |
| mrd_req | output | 1 | Descriptor fetch request |
| mrd_addr | output | 32 | Descriptor address |
| mrd_gnt | input | 1 | Request accepted, with data in the same cycle |
| mrd_data | input | 64 | Descriptor returned |
| rgn_valid | output | 2 | Region offered, one bit per channel |
| rgn_ready | input | 2 | Region taken by the mover, one bit per channel |
| rgn_addr | output | 64 | Region base address, 32 bits per channel |
| rgn_len | output | 32 | Region byte count, 16 bits per channel |
| rgn_to_mem | output | 2 | Direction is device to memory, per channel |
| rgn_last | output | 2 | Region is the last table entry, per channel |

## Verification
The hardest case to reach is the arbiter choosing between two requests that become ready in the same cycle. A register access touches only one channel per cycle, so two start writes can never land in the same cycle. The bench gets there in steps. First it holds grants back while both channels start, which also checks that the first requester keeps ownership. Then it lets both channels park on a region offer. Finally it accepts both offers in the same cycle, with grants held back again, so that both fetches for the next entry go up together. A long random phase of register accesses also covers the rejection rules for every offset, size and channel.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int NCH        = 2;
    localparam int PTR_W      = 32;
    localparam int LEN_W      = 16;
    localparam int DESC_W     = 64;
    localparam int DESC_BYTES = 8;

    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd2;

    localparam int ST_ACTIVE = 0;
    localparam int ST_ERROR  = 1;
    localparam int ST_IRQ    = 2;

    localparam logic [7:0] CMD_KEEP_MASK = 8'h09;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_FETCH = 2'd1,
        ENG_HAND  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic             last;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] base;
    } desc_t;

    function automatic desc_t desc_unpack(input logic [DESC_W-1:0] w);
        desc_t d;
        d.base = w[PTR_W-1:0];
        d.len  = w[PTR_W +: LEN_W];
        d.last = w[DESC_W-1];
        return d;
    endfunction

    // Start byte plus length must stay inside the four pointer bytes.
    function automatic logic ptr_span_ok(input logic [1:0] first, input logic [1:0] sz);
        return ({1'b0, first} + {1'b0, sz}) <= 3'd3;
    endfunction

endpackage

// File: rtl/bmdma_arb.sv
module bmdma_arb #(
    parameter int NREQ = 2,
    parameter int AW   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREQ-1:0]   req,
    input  logic [NREQ*AW-1:0] addr,
    output logic [NREQ-1:0]   gnt,
    output logic              mrd_req,
    output logic [AW-1:0]     mrd_addr,
    input  logic              mrd_gnt
);
    localparam int SW = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic [SW-1:0] own_q, pick, sel;
    logic          lock_q;

    // Lowest index wins among new requests.
    always_comb begin
        pick = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) pick = SW'(i);
        end
    end

    assign sel      = lock_q ? own_q : pick;
    assign mrd_req  = req[sel];
    assign mrd_addr = addr[sel*AW +: AW];

    always_comb begin
        gnt      = '0;
        gnt[sel] = mrd_gnt && req[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            own_q  <= '0;
        end else begin
            lock_q <= mrd_req && !mrd_gnt;
            own_q  <= sel;
        end
    end

    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (rst)
        (mrd_req && !mrd_gnt) |=> (!mrd_req || sel == $past(sel)));  // R11

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && (!(|gnt) || mrd_req));  // R11

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        off,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic              mem_gnt,
    input  logic [DESC_W-1:0] mem_data,
    output logic              rgn_valid,
    input  logic              rgn_ready,
    output logic [PTR_W-1:0]  rgn_addr,
    output logic [LEN_W-1:0]  rgn_len,
    output logic              rgn_to_mem,
    output logic              rgn_last
);
    localparam int PAD_W = PTR_W - IDX_W - $clog2(DESC_BYTES);

    logic [7:0]       cmd_q, stat_q;
    logic [PTR_W-1:0] ptr_q, ptr_nx;
    logic [IDX_W-1:0] idx_q;
    eng_state_e       st_q;
    desc_t            desc_q;

    int   pb_i, sz_i;
    logic is_ptr, cmd_wr, stat_wr, ptr_wr, abort;

    assign pb_i   = int'(off[1:0]);
    assign sz_i   = int'(size);
    assign is_ptr = off[2];

    assign err = ((off == OFF_STAT) && (size != 2'd0)) ||
                 (is_ptr && !ptr_span_ok(off[1:0], size));

    assign cmd_wr  = wr_en && (off == OFF_CMD);
    assign stat_wr = wr_en && (off == OFF_STAT) && !err;
    assign ptr_wr  = wr_en && is_ptr && !err;
    assign abort   = cmd_wr && !wdata[0];

    // Read mux.
    always_comb begin
        rdata = '0;
        if (!err) begin
            if (is_ptr) begin
                for (int j = 0; j < 4; j++) begin
                    if (j <= sz_i && (pb_i + j) < 4) rdata[8*j +: 8] = ptr_q[8*(pb_i+j) +: 8];
                end
            end else if (off == OFF_CMD) begin
                rdata[7:0] = cmd_q;
            end else if (off == OFF_STAT) begin
                rdata[7:0] = stat_q;
            end
        end
    end

    // Byte-wise pointer merge.
    always_comb begin
        ptr_nx = ptr_q;
        for (int k = 0; k < 4; k++) begin
            if (k >= pb_i && k <= pb_i + sz_i) ptr_nx[8*k +: 8] = wdata[8*(k-pb_i) +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            stat_q <= '0;
            ptr_q  <= '0;
            idx_q  <= '0;
            st_q   <= ENG_IDLE;
            desc_q <= '0;
        end else begin
            if (ptr_wr)  ptr_q  <= ptr_nx;
            if (stat_wr) stat_q <= wdata[7:0];
            if (cmd_wr) begin
                if (wdata[0]) begin
                    cmd_q             <= wdata[7:0] & CMD_KEEP_MASK;
                    stat_q[ST_ACTIVE] <= 1'b1;
                    if (st_q == ENG_IDLE) st_q <= ENG_FETCH;
                end else begin
                    cmd_q <= wdata[7:0];
                    idx_q <= '0;
                    st_q  <= ENG_IDLE;
                end
            end
            if (!abort) begin
                case (st_q)
                    ENG_FETCH: begin
                        if (mem_gnt) begin
                            desc_q <= desc_unpack(mem_data);
                            st_q   <= ENG_HAND;
                        end
                    end
                    ENG_HAND: begin
                        if (rgn_ready) begin
                            if (desc_q.last) begin
                                stat_q[ST_ACTIVE] <= 1'b0;
                                stat_q[ST_ERROR]  <= 1'b0;
                                stat_q[ST_IRQ]    <= 1'b1;
                                st_q              <= ENG_IDLE;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                                st_q  <= ENG_FETCH;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign mem_req    = (st_q == ENG_FETCH);
    assign mem_addr   = ptr_q + {{PAD_W{1'b0}}, idx_q, 3'b000};
    assign rgn_valid  = (st_q == ENG_HAND);
    assign rgn_addr   = desc_q.base;
    assign rgn_len    = desc_q.len;
    assign rgn_last   = desc_q.last;
    assign rgn_to_mem = cmd_q[3];

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt && !wr_en) |=> (mem_req && $stable(mem_addr)));  // R11

    AST_EOT_STATUS: assert property (@(posedge clk) disable iff (rst)
        (rgn_valid && rgn_ready && rgn_last && !wr_en) |=>
        (!stat_q[ST_ACTIVE] && !stat_q[ST_ERROR] && stat_q[ST_IRQ] && !rgn_valid));  // R10

    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[0] && !(rgn_valid && rgn_ready)) |=>
        (stat_q[ST_ACTIVE] && cmd_q[0] && (mem_req || rgn_valid)));  // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!mem_req && !rgn_valid));  // R6

    AST_NEXT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (rgn_valid && rgn_ready && !rgn_last && !wr_en) |=>
        (mem_req && mem_addr == $past(mem_addr) + PTR_W'(DESC_BYTES)));  // R9

endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [3:0]           acc_addr,
    input  logic [1:0]           acc_size,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          acc_rdata,
    output logic                 acc_err,
    output logic                 mrd_req,
    output logic [PTR_W-1:0]     mrd_addr,
    input  logic                 mrd_gnt,
    input  logic [DESC_W-1:0]    mrd_data,
    output logic [NCH-1:0]       rgn_valid,
    input  logic [NCH-1:0]       rgn_ready,
    output logic [NCH*PTR_W-1:0] rgn_addr,
    output logic [NCH*LEN_W-1:0] rgn_len,
    output logic [NCH-1:0]       rgn_to_mem,
    output logic [NCH-1:0]       rgn_last
);
    logic [31:0]          ch_rdata [NCH];
    logic [NCH-1:0]       ch_err;
    logic [NCH-1:0]       ch_req, ch_gnt;
    logic [NCH*PTR_W-1:0] ch_addr;
    logic                 chan_sel;

    assign chan_sel = acc_addr[3];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic wr_c;
        assign wr_c = acc_valid && acc_write && (chan_sel == c[0]);

        bmdma_chan #(.IDX_W(IDX_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_c),
            .off        (acc_addr[2:0]),
            .size       (acc_size),
            .wdata      (acc_wdata),
            .rdata      (ch_rdata[c]),
            .err        (ch_err[c]),
            .mem_req    (ch_req[c]),
            .mem_addr   (ch_addr[c*PTR_W +: PTR_W]),
            .mem_gnt    (ch_gnt[c]),
            .mem_data   (mrd_data),
            .rgn_valid  (rgn_valid[c]),
            .rgn_ready  (rgn_ready[c]),
            .rgn_addr   (rgn_addr[c*PTR_W +: PTR_W]),
            .rgn_len    (rgn_len[c*LEN_W +: LEN_W]),
            .rgn_to_mem (rgn_to_mem[c]),
            .rgn_last   (rgn_last[c])
        );
    end

    bmdma_arb #(.NREQ(NCH), .AW(PTR_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (ch_req),
        .addr     (ch_addr),
        .gnt      (ch_gnt),
        .mrd_req  (mrd_req),
        .mrd_addr (mrd_addr),
        .mrd_gnt  (mrd_gnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_rdata <= '0;
            acc_err   <= 1'b0;
        end else if (acc_valid) begin
            acc_err   <= ch_err[chan_sel];
            acc_rdata <= acc_write ? 32'd0 : ch_rdata[chan_sel];
        end
    end

    AST_PTR_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr[2] && !ptr_span_ok(acc_addr[1:0], acc_size)) |=>
        (acc_err && acc_rdata == 32'd0));  // R3

    AST_STAT_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr[2:0] == OFF_STAT && acc_size != 2'd0) |=>
        (acc_err && acc_rdata == 32'd0));  // R4

    AST_HOLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_addr[2:0] == 3'd1 || acc_addr[2:0] == 3'd3)) |=>
        (!acc_err && acc_rdata == 32'd0));  // R2

endmodule

// File: tb/bmdma_regfile_tb.sv
module bmdma_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_gnt = 1'b0;
    logic [63:0] mrd_data = '0;
    logic [1:0]  rgn_valid;
    logic [1:0]  rgn_ready = 2'b00;
    logic [63:0] rgn_addr;
    logic [31:0] rgn_len;
    logic [1:0]  rgn_to_mem, rgn_last;

    int n_run = 0, n_fail = 0;
    logic mem_hold = 1'b0;
    logic done = 1'b0;

    logic [7:0]  m_cmd [2];
    logic [7:0]  m_stat[2];
    logic [31:0] m_ptr [2];

    bmdma_regfile u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .mrd_req(mrd_req),
        .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt), .mrd_data(mrd_data),
        .rgn_valid(rgn_valid), .rgn_ready(rgn_ready), .rgn_addr(rgn_addr),
        .rgn_len(rgn_len), .rgn_to_mem(rgn_to_mem), .rgn_last(rgn_last)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] desc_of(input logic [31:0] a);
        logic [31:0] base;
        logic [15:0] len;
        logic        last;
        base = 32'h8000_0000 | (a << 4);
        len  = a[15:0] ^ 16'h0F0F;
        last = (a[4:3] == 2'b11);
        return {last, 15'd0, len, base};
    endfunction

    // Memory responder: one grant pulse per request, driven just after the edge.
    always @(posedge clk) begin
        #1;
        if (mrd_gnt) mrd_gnt = 1'b0;
        else if (mrd_req && !mem_hold) begin
            mrd_data = desc_of(mrd_addr);
            mrd_gnt  = 1'b1;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic ch, input logic [2:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd, output logic e);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = {ch, off}; acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        rd = acc_rdata;
        e  = acc_err;
    endtask

    // Access plus model update and check.
    task automatic do_acc(input logic wr, input logic ch, input logic [2:0] off, input logic [1:0] sz,
                          input logic [31:0] wd);
        logic [31:0] rd, er;
        logic        e, ee;
        string       tag;
        acc(wr, ch, off, sz, wd, rd, e);
        ee = ((off == 3'd2) && sz != 2'd0) || (off[2] && ({1'b0, off[1:0]} + {1'b0, sz}) > 3'd3);
        er = '0;
        if (!wr && !ee) begin
            if (off == 3'd0) er = {24'd0, m_cmd[ch]};
            else if (off == 3'd2) er = {24'd0, m_stat[ch]};
            else if (off[2]) begin
                for (int j = 0; j <= int'(sz); j++) er[8*j +: 8] = m_ptr[ch][8*(int'(off[1:0])+j) +: 8];
            end
        end
        if (off[2]) tag = "R3";
        else if (off == 3'd2) tag = (sz != 2'd0) ? "R4" : "R5";
        else if (off == 3'd0) tag = "R1";
        else tag = "R2";
        check(e == ee, {tag, " err R12"}, {63'd0, e}, {63'd0, ee});
        check(rd == er, {tag, " rdata R12"}, {32'd0, rd}, {32'd0, er});
        if (wr && !ee) begin
            if (off == 3'd0) m_cmd[ch] = wd[0] ? (wd[7:0] & 8'h09) : wd[7:0];
            else if (off == 3'd2) m_stat[ch] = wd[7:0];
            else if (off[2]) begin
                for (int j = 0; j <= int'(sz); j++) m_ptr[ch][8*(int'(off[1:0])+j) +: 8] = wd[8*j +: 8];
            end
        end
    endtask

    task automatic take(input int ch, input logic [31:0] da, input logic to_mem, input string tag);
        logic [63:0] d;
        int waited = 0;
        while (!rgn_valid[ch] && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        d = desc_of(da);
        check(rgn_valid[ch], {tag, " valid"}, {63'd0, rgn_valid[ch]}, 64'd1);
        check(rgn_addr[32*ch +: 32] == d[31:0], {tag, " R8 addr"}, {32'd0, rgn_addr[32*ch +: 32]}, {32'd0, d[31:0]});
        check(rgn_len[16*ch +: 16] == d[47:32], {tag, " R8 len"}, {48'd0, rgn_len[16*ch +: 16]}, {48'd0, d[47:32]});
        check(rgn_last[ch] == d[63], {tag, " R8 last"}, {63'd0, rgn_last[ch]}, {63'd0, d[63]});
        check(rgn_to_mem[ch] == to_mem, {tag, " R8 dir"}, {63'd0, rgn_to_mem[ch]}, {63'd0, to_mem});
        rgn_ready[ch] = 1'b1;
        @(negedge clk);
        rgn_ready[ch] = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        e;
        int          seed;
        seed = int'($urandom(32'd2024));
        for (int c = 0; c < 2; c++) begin
            m_cmd[c] = '0; m_stat[c] = '0; m_ptr[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        check(rgn_valid == 2'b00 && !mrd_req, "R1 reset idle", {62'd0, rgn_valid}, 64'd0);
        for (int c = 0; c < 2; c++) begin
            do_acc(1'b0, c[0], 3'd0, 2'd0, 0);
            do_acc(1'b0, c[0], 3'd2, 2'd0, 0);
            do_acc(1'b0, c[0], 3'd4, 2'd3, 0);
        end

        // Directed rejection corners
        do_acc(1'b1, 1'b0, 3'd5, 2'd3, 32'hDEADBEEF);  // R3 overrun
        do_acc(1'b1, 1'b0, 3'd7, 2'd0, 32'h0000_00AB); // R3 top byte ok
        do_acc(1'b1, 1'b1, 3'd2, 2'd1, 32'h0000_00FF); // R4 wide write
        do_acc(1'b1, 1'b1, 3'd1, 2'd0, 32'h0000_00FF); // R2 hole
        do_acc(1'b0, 1'b1, 3'd3, 2'd3, 0);             // R2 hole read
        do_acc(1'b0, 1'b0, 3'd4, 2'd3, 0);             // R1 byte order

        // Random register traffic, start bit kept clear
        for (int i = 0; i < 400; i++) begin
            logic [31:0] wd;
            logic [2:0]  off;
            wd  = $urandom;
            off = 3'($urandom_range(0, 7));
            if (off == 3'd0) wd[0] = 1'b0;
            do_acc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), off, 2'($urandom_range(0, 3)), wd);
        end

        // Full walk on channel 0
        do_acc(1'b1, 1'b0, 3'd4, 2'd3, 32'h0000_1000);
        do_acc(1'b1, 1'b0, 3'd2, 2'd0, 32'h62);
        do_acc(1'b1, 1'b0, 3'd0, 2'd0, 32'h00);
        do_acc(1'b1, 1'b0, 3'd0, 2'd0, 32'hFF);            // R7 mask
        do_acc(1'b0, 1'b0, 3'd0, 2'd0, 0);
        m_stat[0] = 8'h63;
        do_acc(1'b0, 1'b0, 3'd2, 2'd0, 0);                 // R7 active
        for (int k = 0; k < 4; k++) take(0, 32'h1000 + 8*k, 1'b1, "R9 ch0 walk");
        @(negedge clk);
        check(!rgn_valid[0] && !mrd_req, "R10 idle after last", {62'd0, rgn_valid}, 64'd0);
        m_stat[0] = 8'h64;
        do_acc(1'b0, 1'b0, 3'd2, 2'd0, 0);                 // R10 status

        // Restart keeps index: single last entry at +24
        do_acc(1'b1, 1'b0, 3'd0, 2'd0, 32'h01);
        take(0, 32'h1018, 1'b0, "R7 index kept");
        @(negedge clk);
        do_acc(1'b0, 1'b0, 3'd2, 2'd0, 0);                 // R10

        // Abort during a held fetch on channel 1
        do_acc(1'b1, 1'b1, 3'd4, 2'd3, 32'h0000_4000);
        do_acc(1'b1, 1'b1, 3'd2, 2'd0, 32'h00);
        do_acc(1'b1, 1'b1, 3'd0, 2'd0, 32'h00);
        mem_hold = 1'b1;
        do_acc(1'b1, 1'b1, 3'd0, 2'd0, 32'h09);
        repeat (2) @(negedge clk);
        check(mrd_req && mrd_addr == 32'h4000, "R7 fetch address", {32'd0, mrd_addr}, 64'h4000);
        do_acc(1'b1, 1'b1, 3'd0, 2'd0, 32'h08);            // R6 abort
        check(!mrd_req && !rgn_valid[1], "R6 abort stops", {63'd0, mrd_req}, 64'd0);
        do_acc(1'b0, 1'b1, 3'd0, 2'd0, 0);                 // R6 stored unmasked
        mem_hold = 1'b0;
        do_acc(1'b1, 1'b1, 3'd0, 2'd0, 32'h01);
        for (int k = 0; k < 4; k++) take(1, 32'h4000 + 8*k, 1'b0, "R9 ch1 walk");
        @(negedge clk);
        m_stat[1] = 8'h04;
        do_acc(1'b0, 1'b1, 3'd2, 2'd0, 0);                 // R10

        // Arbitration: owner held, then channel 0 first on a tie
        do_acc(1'b1, 1'b0, 3'd4, 2'd3, 32'h0000_3000);
        do_acc(1'b1, 1'b1, 3'd4, 2'd3, 32'h0000_2000);
        do_acc(1'b1, 1'b0, 3'd0, 2'd0, 32'h00);
        do_acc(1'b1, 1'b1, 3'd0, 2'd0, 32'h00);
        mem_hold = 1'b1;
        do_acc(1'b1, 1'b1, 3'd0, 2'd0, 32'h01);
        do_acc(1'b1, 1'b0, 3'd0, 2'd0, 32'h01);
        check(mrd_req && mrd_addr == 32'h2000, "R11 owner held", {32'd0, mrd_addr}, 64'h2000);
        mem_hold = 1'b0;
        for (int w = 0; w < 50 && rgn_valid != 2'b11; w++) @(negedge clk);
        check(rgn_valid == 2'b11, "R11 both parked", {62'd0, rgn_valid}, 64'd3);
        mem_hold = 1'b1;
        rgn_ready = 2'b11;
        @(negedge clk);
        rgn_ready = 2'b00;
        check(mrd_req && mrd_addr == 32'h3008, "R11 channel 0 first", {32'd0, mrd_addr}, 64'h3008);
        mem_hold = 1'b0;
        for (int k = 1; k < 4; k++) take(0, 32'h3000 + 8*k, 1'b0, "R11 ch0 drain");
        for (int k = 1; k < 4; k++) take(1, 32'h2000 + 8*k, 1'b0, "R11 ch1 drain");
        @(negedge clk);
        check(rgn_valid == 2'b00 && !mrd_req, "R10 both idle", {62'd0, rgn_valid}, 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule